// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences a small processor subsystem through its two power-save modes. Software issues a one-cycle request strobe together with a mode code selecting Sleep or Idle. The controller then spends a single entry cycle, during which the CPU clock is stopped and a watchdog clear pulse is issued, and settles in the selected mode. Sleep stops the system clock, the oscillator and every peripheral clock. Idle keeps the system clock and gates each peripheral according to its own stop-in-idle bit.

The low-power RC clock is kept alive in a mode only when a consumer needs it. In Sleep that consumer is the watchdog. In Idle it is the watchdog or the fail-safe clock monitor. Two keep bits choose whether each regulator drops to standby in Sleep.

An enabled interrupt, a watchdog time-out or a reset ends either mode. A wake event that lands in the entry cycle is held and acted on as soon as the mode is reached. After a wake the block waits a configurable 2 to 4 cycles before the CPU clock returns. The clock-source selection captured when the request was accepted is presented again on return to run.

Top module: `pmode_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the status code is 0 (run). All clock enables are 1, the peripheral enable vector is all ones, both standby outputs are 0 and the watchdog clear is 0.
- R2: In run, a strobe with mode 0 (Sleep) or 1 (Idle) moves the status code to 1 (enter) for exactly one cycle. In that cycle the watchdog clear is 1 and the CPU clock enable is 0. The next status is 2 for Sleep or 3 for Idle. A strobe with mode 2 or 3, or any strobe outside run, is ignored.
- R3: In Sleep (status 2) the CPU clock enable, system clock enable, fail-safe monitor active output and every peripheral enable are 0.
- R4: The low-power RC enable equals the watchdog enable in Sleep, and equals watchdog enable OR clock-monitor enable in Idle. It is 1 in every other state.
- R5: In Sleep, each regulator standby output is the inverse of its keep bit. Outside Sleep both standby outputs are 0.
- R6: In Idle (status 3) the CPU clock enable is 0 and the system clock enable is 1. Peripheral enable bit i is the inverse of stop-in-idle bit i.
- R7: In Sleep or Idle, a wake source moves the status to 4 (wake) on the next cycle. A wake source is any interrupt that is both pending and enabled, or a watchdog time-out. Pending interrupts that are not enabled do not wake the block.
- R8: A wake source present during the enter cycle is held. The selected mode then lasts exactly one cycle before wake, even if the source has gone away.
- R9: Wake lasts D cycles with the CPU clock enable at 0, then the status returns to 0 with the CPU clock enabled. D is 2, 3 or 4 for a resume setting of 0, 1 or 2-or-3.
- R10: In run, the clock-source output follows its input. In every other state it holds the input value sampled with the accepted request.
- R11: The status code is 0 run, 1 enter, 2 Sleep, 3 Idle, 4 wake.
- R12: An asserted reset returns the block to run from any state without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| ps_req | input | 1 | One-cycle power-save request strobe |
| ps_mode | input | 2 | Mode code: 0 Sleep, 1 Idle, others ignored |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Per-interrupt enable bits |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| vreg_keep | input | 1 | Keep the main regulator active in Sleep |
| vregf_keep | input | 1 | Keep the flash regulator active in Sleep |
| per_idle_stop | input | NPER | Per-peripheral stop-in-idle bits |
| resume_cfg | input | 2 | Idle/Sleep resume delay setting |
| clk_src_in | input | CSW | Clock source currently selected by software |
| clk_src_out | output | CSW | Clock source presented to the clock generator |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock and oscillator enable |
| lprc_en | output | 1 | Low-power RC clock enable |
| fscm_act | output | 1 | Clock monitor running |
| wdt_clr | output | 1 | Watchdog clear pulse |
| vreg_stby | output | 1 | Main regulator standby |
| vregf_stby | output | 1 | Flash regulator standby |
| per_clk_en | output | NPER | Peripheral clock enables |
| status | output | 3 | Current state code |

## Verification
A wrong state shows on the status code one cycle later. It also shows on the clock enables, because every output is decoded directly from the registered state. A lost held wake shows as Sleep or Idle lasting more than one cycle. A wrong resume count shows as the CPU clock returning one or two cycles early or late. A bad capture of the clock source is visible on the first non-run cycle after a request, because the bench changes the input right after the strobe.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_ENTER = 3'd1,
    ST_SLEEP = 3'd2,
    ST_IDLE  = 3'd3,
    ST_WAKE  = 3'd4
  } pm_state_e;

  localparam logic [1:0] MODE_SLEEP = 2'd0;
  localparam logic [1:0] MODE_IDLE  = 2'd1;

  // resume delay in cycles: 2 + min(cfg, 2)
  function automatic logic [2:0] resume_cycles(input logic [1:0] cfg);
    if (cfg >= 2'd2) return 3'd4;
    return 3'd2 + {1'b0, cfg};
  endfunction

  function automatic logic mode_valid(input logic [1:0] m);
    return (m == MODE_SLEEP) || (m == MODE_IDLE);
  endfunction

endpackage

// File: rtl/pmode_wake.sv
module pmode_wake #(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            wdt_timeout,
  output logic            wake_any
);
  logic [NIRQ-1:0] irq_live;

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irq_live[i] = irq_pend[i] & irq_en[i];
  end

  assign wake_any = (|irq_live) | wdt_timeout;

endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
  import pmode_pkg::*;
#(
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ps_req,
  input  logic [1:0]     ps_mode,
  input  logic           wake_any,
  input  logic [1:0]     resume_cfg,
  input  logic [CSW-1:0] clk_src_in,
  output pm_state_e      state,
  output logic [CSW-1:0] clk_src_hold
);
  pm_state_e      st_n;
  logic           idle_q, idle_n;
  logic           held_q, held_n;
  logic [2:0]     cnt_q, cnt_n;
  logic [CSW-1:0] hold_n;

  always_comb begin
    st_n   = state;
    idle_n = idle_q;
    held_n = held_q;
    cnt_n  = cnt_q;
    hold_n = clk_src_hold;
    unique case (state)
      ST_RUN: begin
        if (ps_req && mode_valid(ps_mode)) begin
          st_n   = ST_ENTER;
          idle_n = (ps_mode == MODE_IDLE);
          hold_n = clk_src_in;
          held_n = 1'b0;
        end
      end
      ST_ENTER: begin
        st_n = idle_q ? ST_IDLE : ST_SLEEP;
        if (wake_any) held_n = 1'b1;
      end
      ST_SLEEP, ST_IDLE: begin
        if (wake_any || held_q) begin
          st_n   = ST_WAKE;
          cnt_n  = resume_cycles(resume_cfg);
          held_n = 1'b0;
        end
      end
      ST_WAKE: begin
        if (cnt_q <= 3'd1) st_n = ST_RUN;
        else               cnt_n = cnt_q - 3'd1;
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      idle_q       <= 1'b0;
      held_q       <= 1'b0;
      cnt_q        <= 3'd0;
      clk_src_hold <= '0;
    end else begin
      state        <= st_n;
      idle_q       <= idle_n;
      held_q       <= held_n;
      cnt_q        <= cnt_n;
      clk_src_hold <= hold_n;
    end
  end

endmodule

// File: rtl/pmode_gate.sv
module pmode_gate
  import pmode_pkg::*;
#(
  parameter int NPER = 6
) (
  input  pm_state_e       state,
  input  logic            wdt_en,
  input  logic            fscm_en,
  input  logic            vreg_keep,
  input  logic            vregf_keep,
  input  logic [NPER-1:0] per_idle_stop,
  output logic            cpu_clk_en,
  output logic            sys_clk_en,
  output logic            lprc_en,
  output logic            fscm_act,
  output logic            wdt_clr,
  output logic            vreg_stby,
  output logic            vregf_stby,
  output logic [NPER-1:0] per_clk_en
);
  logic in_sleep, in_idle;

  assign in_sleep = (state == ST_SLEEP);
  assign in_idle  = (state == ST_IDLE);

  assign cpu_clk_en = (state == ST_RUN);
  assign sys_clk_en = !in_sleep;
  assign fscm_act   = fscm_en && !in_sleep;
  assign wdt_clr    = (state == ST_ENTER);
  assign vreg_stby  = in_sleep && !vreg_keep;
  assign vregf_stby = in_sleep && !vregf_keep;

  always_comb begin
    if (in_sleep)     lprc_en = wdt_en;
    else if (in_idle) lprc_en = wdt_en || fscm_en;
    else              lprc_en = 1'b1;
  end

  for (genvar p = 0; p < NPER; p++) begin : g_per
    assign per_clk_en[p] = !in_sleep && !(in_idle && per_idle_stop[p]);
  end

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NPER = 6,
  parameter int CSW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ps_req,
  input  logic [1:0]      ps_mode,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            wdt_timeout,
  input  logic            wdt_en,
  input  logic            fscm_en,
  input  logic            vreg_keep,
  input  logic            vregf_keep,
  input  logic [NPER-1:0] per_idle_stop,
  input  logic [1:0]      resume_cfg,
  input  logic [CSW-1:0]  clk_src_in,
  output logic [CSW-1:0]  clk_src_out,
  output logic            cpu_clk_en,
  output logic            sys_clk_en,
  output logic            lprc_en,
  output logic            fscm_act,
  output logic            wdt_clr,
  output logic            vreg_stby,
  output logic            vregf_stby,
  output logic [NPER-1:0] per_clk_en,
  output logic [2:0]      status
);
  logic           wake_any;
  pm_state_e      state;
  logic [CSW-1:0] clk_src_hold;

  pmode_wake #(.NIRQ(NIRQ)) u_wake (
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .wdt_timeout (wdt_timeout),
    .wake_any    (wake_any)
  );

  pmode_fsm #(.CSW(CSW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ps_req       (ps_req),
    .ps_mode      (ps_mode),
    .wake_any     (wake_any),
    .resume_cfg   (resume_cfg),
    .clk_src_in   (clk_src_in),
    .state        (state),
    .clk_src_hold (clk_src_hold)
  );

  pmode_gate #(.NPER(NPER)) u_gate (
    .state         (state),
    .wdt_en        (wdt_en),
    .fscm_en       (fscm_en),
    .vreg_keep     (vreg_keep),
    .vregf_keep    (vregf_keep),
    .per_idle_stop (per_idle_stop),
    .cpu_clk_en    (cpu_clk_en),
    .sys_clk_en    (sys_clk_en),
    .lprc_en       (lprc_en),
    .fscm_act      (fscm_act),
    .wdt_clr       (wdt_clr),
    .vreg_stby     (vreg_stby),
    .vregf_stby    (vregf_stby),
    .per_clk_en    (per_clk_en)
  );

  assign clk_src_out = (state == ST_RUN) ? clk_src_in : clk_src_hold;
  assign status      = state;

endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk #(
  parameter int NPER = 6,
  parameter int CSW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      status,
  input logic            cpu_clk_en,
  input logic            sys_clk_en,
  input logic            fscm_act,
  input logic            wdt_clr,
  input logic [NPER-1:0] per_clk_en,
  input logic [CSW-1:0]  clk_src_out,
  input logic            wake_any
);
  localparam logic [2:0] S_RUN = 3'd0, S_ENT = 3'd1, S_SLP = 3'd2,
                         S_IDL = 3'd3, S_WAK = 3'd4;

  assert_clr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_clr) |=> !wdt_clr);

  assert_enter_to_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_ENT) |=> (status == S_SLP || status == S_IDL));

  assert_sleep_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_SLP) |-> (!sys_clk_en && !cpu_clk_en && !fscm_act && per_clk_en == '0));

  assert_idle_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_IDL) |-> (sys_clk_en && !cpu_clk_en));

  assert_wake_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_SLP || status == S_IDL) && wake_any) |=> (status == S_WAK));

  assert_held_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == S_ENT) && wake_any) |=> ##1 (status == S_WAK));

  assert_wake_cpu_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == S_WAK) |-> !cpu_clk_en);

  assert_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != S_RUN) |=> (status == S_RUN || $stable(clk_src_out)));

  assert_code_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status <= S_WAK);

endmodule

bind pmode_ctrl pmode_ctrl_chk #(.NPER(NPER), .CSW(CSW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status      (status),
  .cpu_clk_en  (cpu_clk_en),
  .sys_clk_en  (sys_clk_en),
  .fscm_act    (fscm_act),
  .wdt_clr     (wdt_clr),
  .per_clk_en  (per_clk_en),
  .clk_src_out (clk_src_out),
  .wake_any    (wake_any)
);

// File: tb/pmode_ctrl_tb.sv
module pmode_ctrl_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NIRQ = 8;
  localparam int NPER = 6;
  localparam int CSW  = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ps_req;
  logic [1:0]      ps_mode;
  logic [NIRQ-1:0] irq_pend, irq_en;
  logic            wdt_timeout, wdt_en, fscm_en, vreg_keep, vregf_keep;
  logic [NPER-1:0] per_idle_stop;
  logic [1:0]      resume_cfg;
  logic [CSW-1:0]  clk_src_in, clk_src_out;
  logic            cpu_clk_en, sys_clk_en, lprc_en, fscm_act, wdt_clr;
  logic            vreg_stby, vregf_stby;
  logic [NPER-1:0] per_clk_en;
  logic [2:0]      status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [CSW-1:0] saved_src;

  always #2.5ns clk = ~clk;

  pmode_ctrl #(.NIRQ(NIRQ), .NPER(NPER), .CSW(CSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ps_req(ps_req), .ps_mode(ps_mode),
    .irq_pend(irq_pend), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
    .wdt_en(wdt_en), .fscm_en(fscm_en), .vreg_keep(vreg_keep),
    .vregf_keep(vregf_keep), .per_idle_stop(per_idle_stop),
    .resume_cfg(resume_cfg), .clk_src_in(clk_src_in),
    .clk_src_out(clk_src_out), .cpu_clk_en(cpu_clk_en),
    .sys_clk_en(sys_clk_en), .lprc_en(lprc_en), .fscm_act(fscm_act),
    .wdt_clr(wdt_clr), .vreg_stby(vreg_stby), .vregf_stby(vregf_stby),
    .per_clk_en(per_clk_en), .status(status)
  );

  function automatic int exp_delay(input logic [1:0] cfg);
    int d = 2 + int'(cfg);
    return (d > 4) ? 4 : d;
  endfunction

  function automatic logic exp_lprc(input int st);
    case (st)
      2:       return wdt_en;
      3:       return wdt_en | fscm_en;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [NPER-1:0] exp_per(input int st);
    case (st)
      2:       return '0;
      3:       return ~per_idle_stop;
      default: return '1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input int st);
    chk("R11 status", 32'(status), 32'(st));
    chk("R3/R6/R9 cpu_clk_en", 32'(cpu_clk_en), 32'(st == 0));
    chk("R3/R6 sys_clk_en", 32'(sys_clk_en), 32'(st != 2));
    chk("R3 fscm_act", 32'(fscm_act), 32'(fscm_en && st != 2));
    chk("R4 lprc_en", 32'(lprc_en), 32'(exp_lprc(st)));
    chk("R3/R6 per_clk_en", 32'(per_clk_en), 32'(exp_per(st)));
    chk("R5 vreg_stby", 32'(vreg_stby), 32'(st == 2 && !vreg_keep));
    chk("R5 vregf_stby", 32'(vregf_stby), 32'(st == 2 && !vregf_keep));
    chk("R2 wdt_clr", 32'(wdt_clr), 32'(st == 1));
    if (st == 0) chk("R10 src follows", 32'(clk_src_out), 32'(clk_src_in));
    else         chk("R10 src held", 32'(clk_src_out), 32'(saved_src));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_wake(input int kind, input bit on);
    if (!on) begin
      irq_pend = '0; wdt_timeout = 1'b0;
    end else if (kind == 0) begin
      int k = $urandom_range(NIRQ-1);
      irq_en[k] = 1'b1;
      irq_pend = NIRQ'(1) << k;
    end else begin
      wdt_timeout = 1'b1;
    end
  endtask

  // mode: 0 Sleep / 1 Idle; kind: 0 irq, 1 watchdog
  task automatic episode(input int mode, input int kind, input bit early,
                         input int wait_n, input logic [1:0] cfg);
    int st = (mode == 0) ? 2 : 3;
    resume_cfg = cfg;
    clk_src_in = CSW'($urandom);
    saved_src  = clk_src_in;
    ps_mode = 2'(mode); ps_req = 1'b1;
    step();
    ps_req = 1'b0;
    check_state(1);                           // R2 enter cycle
    clk_src_in = ~saved_src;                  // R10: capture must not follow
    if (early) set_wake(kind, 1'b1);
    step();
    check_state(st);
    if (early) begin
      set_wake(kind, 1'b0);                   // R8: source gone, still held
      step();
    end else begin
      for (int i = 0; i < wait_n; i++) begin
        irq_pend = ~irq_en;                   // R7: pending but not enabled
        if (i == 0) begin ps_req = 1'b1; ps_mode = 2'($urandom_range(1)); end // R2 ignored
        step();
        ps_req = 1'b0;
        check_state(st);
      end
      irq_pend = '0;
      set_wake(kind, 1'b1);
      step();
      set_wake(kind, 1'b0);
    end
    for (int i = 0; i < exp_delay(cfg); i++) begin
      check_state(4);                         // R9 wake window
      step();
    end
    check_state(0);                           // R9 back in run
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; ps_req = 1'b0; ps_mode = 2'd0; irq_pend = '0; irq_en = 8'h0F;
    wdt_timeout = 1'b0; wdt_en = 1'b1; fscm_en = 1'b0; vreg_keep = 1'b0;
    vregf_keep = 1'b1; per_idle_stop = 6'b101001; resume_cfg = 2'd0;
    clk_src_in = 3'd5; saved_src = 3'd5;
    repeat (3) @(negedge clk);
    check_state(0);                           // R1 during reset
    rst_n = 1'b1;
    step();
    check_state(0);                           // R1 after release

    // R2: invalid mode codes ignored
    for (int m = 2; m < 4; m++) begin
      ps_mode = 2'(m); ps_req = 1'b1;
      step();
      ps_req = 1'b0;
      check_state(0);
    end

    // directed corner cases
    episode(0, 0, 1'b0, 3, 2'd0);
    episode(1, 1, 1'b0, 2, 2'd1);
    episode(0, 1, 1'b1, 0, 2'd2);             // R8 Sleep early wake
    wdt_en = 1'b0; fscm_en = 1'b1;
    episode(1, 0, 1'b1, 0, 2'd3);             // R8 Idle early wake
    wdt_en = 1'b0; fscm_en = 1'b0; vreg_keep = 1'b1; vregf_keep = 1'b0;
    episode(0, 0, 1'b0, 1, 2'd3);             // R4 lprc off in Sleep

    // R12: reset from Sleep without a clock edge
    clk_src_in = 3'd2; saved_src = 3'd2;
    ps_mode = 2'd0; ps_req = 1'b1;
    step(); ps_req = 1'b0;
    step();
    check_state(2);
    #1ns rst_n = 1'b0;
    #0.5ns;
    chk("R12 async reset status", 32'(status), 32'd0);
    chk("R12 async reset sys_clk_en", 32'(sys_clk_en), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check_state(0);

    // constrained random episodes
    for (int e = 0; e < 40; e++) begin
      wdt_en = 1'($urandom); fscm_en = 1'($urandom);
      vreg_keep = 1'($urandom); vregf_keep = 1'($urandom);
      per_idle_stop = NPER'($urandom);
      irq_en = NIRQ'($urandom);
      episode($urandom_range(1), $urandom_range(1), ($urandom_range(3) == 0),
              $urandom_range(1, 6), 2'($urandom));
      repeat ($urandom_range(2)) begin step(); check_state(0); end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule